// File: doc/BRIEF.md
# Audio Port Control and Status Registers

This block is the register front end of a serial audio port. A simple word-addressed bus reaches two 32-bit registers: a control word that configures the port and a status word that reports its condition. Each register has three views. The plain view replaces the value. The set view ORs the written ones into it. The clear view removes the written ones. Software can therefore flip single bits without a read-modify-write sequence.

The control word holds the port's configuration: soft reset, clock gate, run, receive direction, follower timing, bit-clock edge, frame-clock polarity, one-bit data delay, justification, sample width code, 48x-fs enable, a base-rate select, a rate multiplier and the FIFO error interrupt enable. Soft reset and clock gate both come out of reset set, and software clears both before the port runs. The serial engine is outside this block. It reports a busy level and single-cycle underflow and overflow strobes. The strobes set sticky flags in the status word, and the flags drive a registered interrupt.

Top module: `audio_ctl_regs`

## Requirements
- R1: After reset the control word reads 0xC000_0000 (soft reset bit 31 and clock gate bit 30 set), the status word reads 0 and `irq` is low.
- R2: A write to byte address 0x00 replaces the control word. Bits outside the implemented set read as zero. Implemented: run 0, receive 1, follower 2, clock edge 3, frame polarity 4, delay 5, justify 6, width code 11:8 (0 = 16-bit, 4 = 20-bit, 8 = 24-bit), 48x-fs enable 12, base rate 13, multiplier 18:16, error interrupt enable 20, clock gate 30, soft reset 31. This gives mask 0xC017_3F7F.
- R3: A write to 0x04 ORs the write data into the control word. Bits written as 0 keep their value.
- R4: A write to 0x08 clears every control bit written as 1. All other bits keep their value.
- R5: Reads at 0x04/0x08 and 0x14/0x18 return the current register value. Offsets 0x0C and 0x1C, and any address with bits 1:0 nonzero, read as 0 and ignore writes.
- R6: Status bit 0 (busy) shows `busyIn` as sampled at the previous clock edge.
- R7: An `underflowEv` or `overflowEv` strobe sets status bit 4 or bit 5. The flag stays set until software clears it.
- R8: Writing a 1 to bit 4 or bit 5 at 0x18 clears that flag. Writes to 0x10 and 0x14 leave the status word unchanged.
- R9: When a strobe and a clear of the same flag fall in the same cycle, the flag ends up set.
- R10: From the cycle after soft reset becomes set, and for as long as it stays set, busy and both flags read 0, and strobes are ignored.
- R11: `irq` equals, one cycle later, (bit 4 OR bit 5) AND control bit 20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busSel | input | 1 | Bus access strobe, one cycle per access |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 5 | Byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from address |
| busyIn | input | 1 | Serial engine transfer active |
| underflowEv | input | 1 | FIFO underflow strobe |
| overflowEv | input | 1 | FIFO overflow strobe |
| ctrlOut | output | 32 | Current control word |
| irq | output | 1 | FIFO error interrupt |

## Verification
Register writes take effect at the clock edge that captures them. Read data is combinational, so the bench samples a read on the falling edge of the same cycle the address is presented. A strobe or a busy change shows in the status word one edge after it is driven. The interrupt follows one edge after that. The bench therefore checks `irq` one cycle later than the flag. Every compare happens in the monitor at the falling edge that follows the edge at which the design's result is due, so no check races a register update.

// File: rtl/audio_regs_pkg.sv
package audio_regs_pkg;
  parameter int DATA_W = 32;
  parameter int ADDR_W = 5;

  localparam int ALIAS_LSB = 2;
  localparam int REG_BIT   = 4;
  localparam int FLAG_N    = 2;

  // control field positions
  localparam int BIT_RUN   = 0;
  localparam int BIT_EN    = 20;
  localparam int BIT_GATE  = 30;
  localparam int BIT_SRST  = 31;

  // status positions
  localparam int BIT_BUSY  = 0;
  localparam int FLAG_BASE = 4;

  localparam logic [DATA_W-1:0] CTRL_MASK = 32'hC017_3F7F;
  localparam logic [DATA_W-1:0] CTRL_RST  = 32'hC000_0000;

  typedef enum logic [1:0] {
    VIEW_PLAIN = 2'd0,
    VIEW_SET   = 2'd1,
    VIEW_CLR   = 2'd2,
    VIEW_NONE  = 2'd3
  } regView_e;

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_CTRL = 2'd1,
    RD_STAT = 2'd2
  } rdSel_e;

  typedef struct packed {
    logic ctrlPlain;
    logic ctrlSet;
    logic ctrlClr;
    logic statClr;
  } regStrobes_t;
endpackage

// File: rtl/audio_regs_decode.sv
module audio_regs_decode
  import audio_regs_pkg::*;
(
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output regStrobes_t       stb,
  output rdSel_e            rdSel
);
  logic     addrOk;
  logic     upperZero;
  regView_e view;
  logic     isStat;

  generate
    if (ADDR_W > REG_BIT + 1) begin : g_upper
      assign upperZero = (busAddr[ADDR_W-1:REG_BIT+1] == '0);
    end else begin : g_noUpper
      assign upperZero = 1'b1;
    end
  endgenerate

  assign view   = regView_e'(busAddr[ALIAS_LSB +: 2]);
  assign isStat = busAddr[REG_BIT];
  assign addrOk = upperZero && (busAddr[ALIAS_LSB-1:0] == '0) && (view != VIEW_NONE);

  always_comb begin
    stb = '0;
    if (busSel && busWr && addrOk) begin
      if (!isStat) begin
        stb.ctrlPlain = (view == VIEW_PLAIN);
        stb.ctrlSet   = (view == VIEW_SET);
        stb.ctrlClr   = (view == VIEW_CLR);
      end else begin
        stb.statClr   = (view == VIEW_CLR);
      end
    end
  end

  always_comb begin
    if (!addrOk)     rdSel = RD_NONE;
    else if (isStat) rdSel = RD_STAT;
    else             rdSel = RD_CTRL;
  end
endmodule

// File: rtl/audio_regs_datapath.sv
module audio_regs_datapath
  import audio_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  regStrobes_t       stb,
  input  logic [DATA_W-1:0] wdata,
  input  logic              busyIn,
  input  logic [FLAG_N-1:0] flagEv,
  output logic [DATA_W-1:0] ctrlQ,
  output logic [DATA_W-1:0] statQ,
  output logic              irqQ
);
  logic [DATA_W-1:0] ctrlNext;
  logic [FLAG_N-1:0] flagQ;
  logic              busyQ;
  logic              softRst;

  assign softRst = ctrlQ[BIT_SRST];

  always_comb begin
    ctrlNext = ctrlQ;
    if (stb.ctrlPlain)    ctrlNext = wdata & CTRL_MASK;
    else if (stb.ctrlSet) ctrlNext = (ctrlQ | wdata) & CTRL_MASK;
    else if (stb.ctrlClr) ctrlNext = ctrlQ & ~wdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctrlQ <= CTRL_RST;
    else       ctrlQ <= ctrlNext;
  end

  genvar g;
  generate
    for (g = 0; g < FLAG_N; g++) begin : g_flag
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                                     flagQ[g] <= 1'b0;
        else if (softRst)                              flagQ[g] <= 1'b0;
        else if (flagEv[g])                            flagQ[g] <= 1'b1;
        else if (stb.statClr && wdata[FLAG_BASE + g])  flagQ[g] <= 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      irqQ  <= 1'b0;
    end else begin
      busyQ <= busyIn && !softRst;
      irqQ  <= ctrlQ[BIT_EN] && (|flagQ);
    end
  end

  always_comb begin
    statQ = '0;
    statQ[BIT_BUSY] = busyQ;
    statQ[FLAG_BASE +: FLAG_N] = flagQ;
  end
endmodule

// File: rtl/audio_ctl_regs.sv
module audio_ctl_regs
  import audio_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              busyIn,
  input  logic              underflowEv,
  input  logic              overflowEv,
  output logic [DATA_W-1:0] ctrlOut,
  output logic              irq
);
  regStrobes_t       stb;
  rdSel_e            rdSel;
  logic [DATA_W-1:0] statusWord;

  audio_regs_decode u_decode (
    .busSel (busSel),
    .busWr  (busWr),
    .busAddr(busAddr),
    .stb    (stb),
    .rdSel  (rdSel)
  );

  audio_regs_datapath u_datapath (
    .clk   (clk),
    .rstN  (rstN),
    .stb   (stb),
    .wdata (busWdata),
    .busyIn(busyIn),
    .flagEv({overflowEv, underflowEv}),
    .ctrlQ (ctrlOut),
    .statQ (statusWord),
    .irqQ  (irq)
  );

  always_comb begin
    case (rdSel)
      RD_CTRL: busRdata = ctrlOut;
      RD_STAT: busRdata = statusWord;
      default: busRdata = '0;
    endcase
  end
endmodule

// File: rtl/audio_ctl_regs_checker.sv
module audio_ctl_regs_checker
  import audio_regs_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWr,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic              busyIn,
  input logic              underflowEv,
  input logic              overflowEv,
  input logic [DATA_W-1:0] ctrlOut,
  input logic [DATA_W-1:0] statusWord,
  input logic              irq
);
  logic wrCtrlPlain, wrCtrlSet, wrCtrlClr, wrStatClr;
  assign wrCtrlPlain = busSel && busWr && (busAddr == 5'h00);
  assign wrCtrlSet   = busSel && busWr && (busAddr == 5'h04);
  assign wrCtrlClr   = busSel && busWr && (busAddr == 5'h08);
  assign wrStatClr   = busSel && busWr && (busAddr == 5'h18);

  AST_PLAIN_REPLACE: assert property (@(posedge clk) disable iff (!rstN)
    wrCtrlPlain |=> ctrlOut == ($past(busWdata) & CTRL_MASK)); // R2
  AST_SET_ORS: assert property (@(posedge clk) disable iff (!rstN)
    wrCtrlSet |=> ctrlOut == (($past(ctrlOut) | $past(busWdata)) & CTRL_MASK)); // R3
  AST_CLR_ANDN: assert property (@(posedge clk) disable iff (!rstN)
    wrCtrlClr |=> ctrlOut == ($past(ctrlOut) & ~$past(busWdata))); // R4
  AST_BUSY_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlOut[BIT_SRST] |=> statusWord[BIT_BUSY] == $past(busyIn)); // R6
  AST_UF_EVENT_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (underflowEv && !ctrlOut[BIT_SRST]) |=> statusWord[FLAG_BASE]); // R9
  AST_OF_EVENT_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (overflowEv && !ctrlOut[BIT_SRST]) |=> statusWord[FLAG_BASE+1]); // R9
  AST_UF_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    (wrStatClr && busWdata[FLAG_BASE] && !underflowEv) |=> !statusWord[FLAG_BASE]); // R8
  AST_SRST_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    ctrlOut[BIT_SRST] |=> statusWord == '0); // R10
  AST_IRQ_LAG: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> irq == ($past(ctrlOut[BIT_EN]) && ($past(statusWord[FLAG_BASE]) || $past(statusWord[FLAG_BASE+1])))); // R11
endmodule

bind audio_ctl_regs audio_ctl_regs_checker u_checker (
  .clk        (clk),
  .rstN       (rstN),
  .busSel     (busSel),
  .busWr      (busWr),
  .busAddr    (busAddr),
  .busWdata   (busWdata),
  .busyIn     (busyIn),
  .underflowEv(underflowEv),
  .overflowEv (overflowEv),
  .ctrlOut    (ctrlOut),
  .statusWord (statusWord),
  .irq        (irq)
);

// File: tb/audio_ctl_regs_tb.sv
`timescale 1ns/1ps
module audio_ctl_regs_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0, busWr = 1'b0;
  logic [4:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        busyIn = 1'b0, underflowEv = 1'b0, overflowEv = 1'b0;
  logic [31:0] ctrlOut;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [31:0] exp;
    bit          isIrq;
    string       tag;
  } item_t;
  item_t sbQ[$];
  logic  chkPend = 1'b0;

  always #4 clk = ~clk;

  audio_ctl_regs u_dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .busyIn(busyIn),
    .underflowEv(underflowEv), .overflowEv(overflowEv), .ctrlOut(ctrlOut), .irq(irq)
  );

  // monitor: compare at the falling edge
  always @(negedge clk) begin
    if (chkPend && sbQ.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sbQ.pop_front();
      act = it.isIrq ? {31'd0, irq} : busRdata;
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s actual=%08h expected=%08h", it.tag, act, it.exp);
      end
    end
  end

  task automatic busWrite(input logic [4:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    busSel = 1; busWr = 1; busAddr = a; busWdata = d;
    @(posedge clk); #1;
    busSel = 0; busWr = 0; busWdata = '0;
  endtask

  task automatic busRead(input logic [4:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(posedge clk); #1;
    busSel = 1; busWr = 0; busAddr = a;
    it.exp = e; it.isIrq = 0; it.tag = tag;
    sbQ.push_back(it);
    chkPend = 1;
    @(posedge clk); #1;
    chkPend = 0; busSel = 0;
  endtask

  task automatic irqCheck(input logic e, input string tag);
    item_t it;
    @(posedge clk); #1;
    it.exp = {31'd0, e}; it.isIrq = 1; it.tag = tag;
    sbQ.push_back(it);
    chkPend = 1;
    @(posedge clk); #1;
    chkPend = 0;
  endtask

  task automatic pulseEv(input bit uf, input bit of);
    @(posedge clk); #1;
    underflowEv = uf; overflowEv = of;
    @(posedge clk); #1;
    underflowEv = 0; overflowEv = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    // R1 reset state
    busRead(5'h00, 32'hC000_0000, "R1 ctrl reset");
    busRead(5'h10, 32'h0, "R1 status reset");
    irqCheck(1'b0, "R1 irq reset");
    // R4 clear alias
    busWrite(5'h08, 32'hC000_0000);
    busRead(5'h00, 32'h0, "R4 clear soft reset and gate");
    // R3 set alias, R5 alias reads
    busWrite(5'h04, 32'h0010_0021);
    busRead(5'h04, 32'h0010_0021, "R3 R5 set alias read");
    busRead(5'h08, 32'h0010_0021, "R5 clear alias read");
    busWrite(5'h08, 32'h0000_0001);
    busRead(5'h00, 32'h0010_0020, "R4 clear keeps others");
    busWrite(5'h04, 32'h0000_0100);
    busRead(5'h00, 32'h0010_0120, "R3 set keeps others");
    // R2 plain writes and mask
    busWrite(5'h00, 32'hFFFF_FFFF);
    busRead(5'h00, 32'hC017_3F7F, "R2 mask");
    busWrite(5'h00, 32'h0010_1801);
    busRead(5'h00, 32'h0010_1801, "R2 24-bit config");
    // R5 unused offsets
    busWrite(5'h0C, 32'hFFFF_FFFF);
    busWrite(5'h02, 32'hFFFF_FFFF);
    busRead(5'h00, 32'h0010_1801, "R5 ignored writes");
    busRead(5'h0C, 32'h0, "R5 unused read");
    // R6 busy
    busyIn = 1;
    busRead(5'h10, 32'h1, "R6 busy high");
    busyIn = 0;
    busRead(5'h10, 32'h0, "R6 busy low");
    // R7 sticky flags, R11 irq
    pulseEv(1, 0);
    irqCheck(1'b1, "R11 irq on underflow");
    busRead(5'h10, 32'h10, "R7 underflow sticky");
    pulseEv(0, 1);
    busRead(5'h18, 32'h30, "R7 both flags");
    // R8 plain and set writes to status ignored
    busWrite(5'h10, 32'h0);
    busWrite(5'h14, 32'hFFFF_FFFF);
    busRead(5'h10, 32'h30, "R8 status writes ignored");
    busWrite(5'h18, 32'h10);
    busRead(5'h10, 32'h20, "R8 clear underflow");
    irqCheck(1'b1, "R11 irq held by overflow");
    busWrite(5'h18, 32'h20);
    irqCheck(1'b0, "R11 irq drops");
    busRead(5'h10, 32'h0, "R8 clear overflow");
    // R9 event beats clear
    @(posedge clk); #1;
    busSel = 1; busWr = 1; busAddr = 5'h18; busWdata = 32'h10; underflowEv = 1;
    @(posedge clk); #1;
    busSel = 0; busWr = 0; busWdata = '0; underflowEv = 0;
    busRead(5'h10, 32'h10, "R9 event wins");
    busWrite(5'h18, 32'h30);
    // R11 enable off
    busWrite(5'h08, 32'h0010_0000);
    pulseEv(0, 1);
    irqCheck(1'b0, "R11 irq gated off");
    busRead(5'h10, 32'h20, "R7 overflow with irq off");
    // R10 soft reset holds status clear
    busWrite(5'h04, 32'h8000_0000);
    busRead(5'h10, 32'h0, "R10 flags cleared");
    busyIn = 1;
    pulseEv(1, 1);
    busRead(5'h10, 32'h0, "R10 events ignored");
    busyIn = 0;
    busWrite(5'h08, 32'h8000_0000);
    busRead(5'h00, 32'h0000_1801, "R4 soft reset released");
    busRead(5'h10, 32'h0, "R10 flags stay clear after release");
    repeat (2) @(posedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule